// File: doc/BRIEF.md
# Anti-Starvation Priority Queue Scheduler

This block holds records of a fixed width in a small set of priority queues kept in on-chip registers, and hands them to one output editor. Records arrive on an enqueue stream, each tagged with its priority level. A second input stream carries write-back records, which are records sent back for another round of multicast handling. A write-back record joins the tail of the queue named by its priority tag.

Records leave through two output streams: the editor port and a software port. Both ports always present the same candidate record. Under strict priority this is the head of the highest-priority non-empty queue. A per-queue age counter modifies that choice. The counter of every non-empty queue that is passed over grows by one on each removal. A queue whose counter reaches the limit is served on the next removal, and its counter then clears.

Back-pressure rules:
- A record is taken on an input stream only in a cycle where valid and ready are both high.
- Ready drops whenever the target queue is full, so no record is ever dropped or overwritten.
- An output record is removed only in a cycle where the consumer's ready is high and a record is offered.

Top module: `pq_sched`

## Requirements
- R1: After reset every queue is empty, `ed_valid` and `sw_valid` are low, and `enq_ready` and `wb_ready` are high.
- R2: An enqueue handshake stores the record at the tail of queue `enq_prio`. Records of one queue leave in arrival order.
- R3: Each queue holds 16 records. While the addressed queue is full, the matching ready is low, no record is taken, and the stored records stay intact.
- R4: Without starvation, the record offered is the head of the non-empty queue with the lowest level number. Level 0 is the highest priority.
- R5: Each removal adds one to the age of every other non-empty queue. Once a queue's age is 8, that queue is served on the next removal even if a higher level holds records, and its age returns to 0.
- R6: The software port offers the same record as the editor port. When `sw_ready` is high, `ed_valid` is low and only the software port removes the record.
- R7: A write-back handshake appends its record to the tail of queue `wb_prio`. While `wb_valid` is high, `enq_ready` is low, so the write-back wins a same-cycle conflict.
- R8: `ed_prio` and `sw_prio` give the level of the offered record. `sw_valid` is high exactly when some queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New record offered |
| enq_ready | output | 1 | New record can be taken |
| enq_prio | input | 2 | Level of new record (0 highest) |
| enq_data | input | 16 | New record |
| wb_valid | input | 1 | Write-back record offered |
| wb_ready | output | 1 | Write-back record can be taken |
| wb_prio | input | 2 | Level of write-back record |
| wb_data | input | 16 | Write-back record |
| ed_ready | input | 1 | Editor wants a record |
| ed_valid | output | 1 | Record offered to editor |
| ed_prio | output | 2 | Level of offered record |
| ed_data | output | 16 | Offered record |
| sw_ready | input | 1 | Software wants a record |
| sw_valid | output | 1 | Record offered to software |
| sw_prio | output | 2 | Level of offered record |
| sw_data | output | 16 | Offered record |

## Verification
Two pairs of functions can meet in a single cycle: the two readers, and the two writers. The bench raises `sw_ready` and `ed_ready` on the same clock edge with two queues loaded. It then checks three things: `ed_valid` is low, the software port receives the highest-priority head, and the editor gets the next record on the cycle after. For the writers, it drives a write-back and an enqueue to the same level at once. It checks that `enq_ready` is low and `wb_ready` is high, then re-sends the enqueue. The drain order must show the write-back record first.

// File: rtl/pq_sched_pkg.sv
package pq_sched_pkg;
  localparam int DEF_LEVELS    = 4;
  localparam int DEF_DEPTH     = 16;
  localparam int DEF_REC_W     = 16;
  localparam int DEF_AGE_LIMIT = 8;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_NEW   = 2'd1,
    WR_AGAIN = 2'd2
  } wr_src_e;
endpackage

// File: rtl/pq_queue.sv
module pq_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          nonempty
);
  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wr_ptr, rd_ptr;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign head     = mem[rd_ptr];
  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
endmodule

// File: rtl/pq_age.sv
module pq_age #(
  parameter int N     = 4,
  parameter int LIMIT = 8,
  localparam int PW   = (N > 1) ? $clog2(N) : 1,
  localparam int AW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [PW-1:0] sel,
  input  logic [N-1:0]  nonempty,
  output logic [N-1:0]  starved,
  output logic [N*AW-1:0] age_flat
);
  for (genvar q = 0; q < N; q++) begin : g_age
    logic [AW-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age <= '0;
      end else if (pop) begin
        if (sel == PW'(q))
          age <= '0;
        else if (nonempty[q] && age != AW'(LIMIT))
          age <= age + AW'(1);
      end else if (!nonempty[q]) begin
        age <= '0;
      end
    end
    assign starved[q] = nonempty[q] && (age == AW'(LIMIT));
    assign age_flat[q*AW +: AW] = age;
  end
endmodule

// File: rtl/pq_select.sv
module pq_select #(
  parameter int N   = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  nonempty,
  input  logic [N-1:0]  starved,
  output logic [PW-1:0] sel,
  output logic          any
);
  logic hit;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (starved[i]) begin
        sel = PW'(i);
        hit = 1'b1;
      end
    end
    if (!hit) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (nonempty[i]) sel = PW'(i);
      end
    end
  end

  assign any = |nonempty;
endmodule

// File: rtl/pq_sched.sv
module pq_sched
  import pq_sched_pkg::*;
#(
  parameter int NUM_Q     = DEF_LEVELS,
  parameter int DEPTH     = DEF_DEPTH,
  parameter int REC_W     = DEF_REC_W,
  parameter int AGE_LIMIT = DEF_AGE_LIMIT,
  localparam int PW       = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int AW       = $clog2(AGE_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [PW-1:0]    enq_prio,
  input  logic [REC_W-1:0] enq_data,
  input  logic             wb_valid,
  output logic             wb_ready,
  input  logic [PW-1:0]    wb_prio,
  input  logic [REC_W-1:0] wb_data,
  input  logic             ed_ready,
  output logic             ed_valid,
  output logic [PW-1:0]    ed_prio,
  output logic [REC_W-1:0] ed_data,
  input  logic             sw_ready,
  output logic             sw_valid,
  output logic [PW-1:0]    sw_prio,
  output logic [REC_W-1:0] sw_data
);
  logic [REC_W-1:0]  head_q [NUM_Q];
  logic [NUM_Q-1:0]  full_q, nonempty_q, starved_q, wr_en_q, rd_en_q;
  logic [NUM_Q*CW-1:0] count_flat;
  logic [NUM_Q*AW-1:0] age_flat;
  logic [PW-1:0]     sel;
  logic              any, pop;
  wr_src_e           src;
  logic [REC_W-1:0]  wr_data;
  logic [PW-1:0]     wr_prio;

  // write side: write-back wins over a new record
  assign wb_ready  = !full_q[wb_prio];
  assign enq_ready = !wb_valid && !full_q[enq_prio];

  always_comb begin
    if (wb_valid && wb_ready)        src = WR_AGAIN;
    else if (enq_valid && enq_ready) src = WR_NEW;
    else                             src = WR_NONE;
  end

  assign wr_data = (src == WR_AGAIN) ? wb_data : enq_data;
  assign wr_prio = (src == WR_AGAIN) ? wb_prio : enq_prio;

  // read side: software has first claim
  assign pop      = any && (sw_ready || ed_ready);
  assign sw_valid = any;
  assign ed_valid = any && !sw_ready;
  assign sw_data  = head_q[sel];
  assign ed_data  = head_q[sel];
  assign sw_prio  = sel;
  assign ed_prio  = sel;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign wr_en_q[q] = (src != WR_NONE) && (wr_prio == PW'(q));
    assign rd_en_q[q] = pop && (sel == PW'(q));
    pq_queue #(.DEPTH(DEPTH), .W(REC_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_q[q]),
      .wr_data  (wr_data),
      .rd_en    (rd_en_q[q]),
      .head     (head_q[q]),
      .count    (count_flat[q*CW +: CW]),
      .full     (full_q[q]),
      .nonempty (nonempty_q[q])
    );
  end

  pq_age #(.N(NUM_Q), .LIMIT(AGE_LIMIT)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (pop),
    .sel      (sel),
    .nonempty (nonempty_q),
    .starved  (starved_q),
    .age_flat (age_flat)
  );

  pq_select #(.N(NUM_Q)) u_sel (
    .nonempty (nonempty_q),
    .starved  (starved_q),
    .sel      (sel),
    .any      (any)
  );
endmodule

// File: rtl/pq_sched_chk.sv
module pq_sched_chk #(
  parameter int N     = 4,
  parameter int DEPTH = 16,
  parameter int W     = 16,
  parameter int LIMIT = 8,
  localparam int PW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic [PW-1:0] enq_prio,
  input logic          wb_valid,
  input logic          ed_valid,
  input logic          sw_valid,
  input logic          sw_ready,
  input logic [PW-1:0] ed_prio,
  input logic [PW-1:0] sw_prio,
  input logic [W-1:0]  ed_data,
  input logic [W-1:0]  sw_data,
  input logic [N*CW-1:0] count_flat,
  input logic [N*AW-1:0] age_flat
);
  a_r6_sw_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready) |-> !ed_valid);

  a_r6_same_pick: assert property (@(posedge clk) disable iff (!rst_n)
    ed_valid |-> (sw_valid && ed_data == sw_data && ed_prio == sw_prio));

  a_r7_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !enq_ready);

  a_r2_enq_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready) |=> sw_valid);

  for (genvar q = 0; q < N; q++) begin : g_chk
    a_r5_age_cap: assert property (@(posedge clk) disable iff (!rst_n)
      age_flat[q*AW +: AW] <= AW'(LIMIT));
    a_r3_full_block: assert property (@(posedge clk) disable iff (!rst_n)
      (count_flat[q*CW +: CW] == CW'(DEPTH) && enq_prio == PW'(q)) |-> !enq_ready);
  end
endmodule

bind pq_sched pq_sched_chk #(
  .N(NUM_Q), .DEPTH(DEPTH), .W(REC_W), .LIMIT(AGE_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .enq_prio(enq_prio), .wb_valid(wb_valid), .ed_valid(ed_valid),
  .sw_valid(sw_valid), .sw_ready(sw_ready), .ed_prio(ed_prio),
  .sw_prio(sw_prio), .ed_data(ed_data), .sw_data(sw_data),
  .count_flat(count_flat), .age_flat(age_flat)
);

// File: tb/pq_sched_bench.sv
`timescale 1ns/1ps
module pq_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0, wb_valid = 1'b0, ed_ready = 1'b0, sw_ready = 1'b0;
  logic [1:0]  enq_prio = '0, wb_prio = '0;
  logic [15:0] enq_data = '0, wb_data = '0;
  logic        enq_ready, wb_ready, ed_valid, sw_valid;
  logic [1:0]  ed_prio, sw_prio;
  logic [15:0] ed_data, sw_data;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  pq_sched u_pq_sched (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_prio(enq_prio), .enq_data(enq_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_prio(wb_prio), .wb_data(wb_data),
    .ed_ready(ed_ready), .ed_valid(ed_valid), .ed_prio(ed_prio), .ed_data(ed_data),
    .sw_ready(sw_ready), .sw_valid(sw_valid), .sw_prio(sw_prio), .sw_data(sw_data)
  );

  // op: 0 enqueue, 1 write-back, 2 editor pop, 3 software pop; {op, prio, data}
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 2'd2, 16'h2001},
    {2'd0, 2'd0, 16'h0001},
    {2'd1, 2'd1, 16'h1001},
    {2'd0, 2'd3, 16'h3001},
    {2'd2, 2'd0, 16'h0001},
    {2'd3, 2'd1, 16'h1001},
    {2'd2, 2'd2, 16'h2001},
    {2'd2, 2'd3, 16'h3001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic wb, input logic [1:0] p, input logic [15:0] d, input string tag);
    @(negedge clk);
    if (wb) begin wb_valid = 1'b1; wb_prio = p; wb_data = d; end
    else    begin enq_valid = 1'b1; enq_prio = p; enq_data = d; end
    #1;
    chk(tag, wb ? wb_ready : enq_ready, 1);
    @(posedge clk); #1;
    wb_valid = 1'b0; enq_valid = 1'b0;
  endtask

  task automatic take(input logic sw, input logic [1:0] p, input logic [15:0] d, input string tag);
    @(negedge clk);
    if (sw) sw_ready = 1'b1; else ed_ready = 1'b1;
    #1;
    if (sw) chk(tag, {sw_valid, sw_prio, sw_data}, {1'b1, p, d});
    else    chk(tag, {ed_valid, ed_prio, ed_data}, {1'b1, p, d});
    @(posedge clk); #1;
    sw_ready = 1'b0; ed_ready = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valids", {ed_valid, sw_valid}, 0);
    chk("R1 reset readies", {enq_ready, wb_ready}, 2'b11);

    // table walk: R2 R4 R6 R7 R8
    foreach (VEC[i]) begin
      case (VEC[i][19:18])
        2'd0: put(1'b0, VEC[i][17:16], VEC[i][15:0], "R2 enqueue");
        2'd1: put(1'b1, VEC[i][17:16], VEC[i][15:0], "R7 write-back");
        2'd2: take(1'b0, VEC[i][17:16], VEC[i][15:0], "R4 R8 editor order");
        default: take(1'b1, VEC[i][17:16], VEC[i][15:0], "R6 software order");
      endcase
    end
    @(negedge clk);
    chk("R8 empty after drain", sw_valid, 0);

    // R5 starvation: 10 on level 0, one on level 1
    for (int i = 0; i < 10; i++) put(1'b0, 2'd0, 16'h0100 + 16'(i), "R2 fill level0");
    put(1'b0, 2'd1, 16'h1100, "R2 fill level1");
    for (int i = 0; i < 8; i++) take(1'b0, 2'd0, 16'h0100 + 16'(i), "R4 strict before limit");
    take(1'b0, 2'd1, 16'h1100, "R5 starved level served");
    take(1'b0, 2'd0, 16'h0108, "R5 back to level0");
    take(1'b0, 2'd0, 16'h0109, "R5 level0 tail");

    // R3 full queue
    for (int i = 0; i < 16; i++) put(1'b0, 2'd2, 16'h2100 + 16'(i), "R3 fill");
    @(negedge clk);
    enq_valid = 1'b1; enq_prio = 2'd2; enq_data = 16'h2BAD;
    #1 chk("R3 full refuses", enq_ready, 0);
    @(posedge clk); #1 enq_valid = 1'b0;
    for (int i = 0; i < 16; i++) take(1'b0, 2'd2, 16'h2100 + 16'(i), "R3 contents intact");
    @(negedge clk);
    chk("R3 nothing extra", ed_valid, 0);

    // R6 simultaneous readers
    put(1'b0, 2'd3, 16'h3333, "R2 load");
    put(1'b0, 2'd1, 16'h1111, "R2 load");
    @(negedge clk);
    sw_ready = 1'b1; ed_ready = 1'b1;
    #1 chk("R6 editor held off", ed_valid, 0);
    chk("R6 software gets head", {sw_valid, sw_prio, sw_data}, {1'b1, 2'd1, 16'h1111});
    @(posedge clk); #1 sw_ready = 1'b0; ed_ready = 1'b0;
    take(1'b0, 2'd3, 16'h3333, "R6 editor next");

    // R7 write-back versus enqueue, and tail placement
    @(negedge clk);
    wb_valid = 1'b1; wb_prio = 2'd0; wb_data = 16'h0BBB;
    enq_valid = 1'b1; enq_prio = 2'd0; enq_data = 16'h0CCC;
    #1 chk("R7 enqueue blocked", {enq_ready, wb_ready}, 2'b01);
    @(posedge clk); #1 wb_valid = 1'b0; enq_valid = 1'b0;
    put(1'b0, 2'd0, 16'h0CCC, "R2 retry");
    put(1'b0, 2'd2, 16'h2222, "R2 load");
    put(1'b1, 2'd2, 16'h2223, "R7 wb to loaded queue");
    take(1'b0, 2'd0, 16'h0BBB, "R7 wb first");
    take(1'b1, 2'd0, 16'h0CCC, "R7 enq after");
    take(1'b0, 2'd2, 16'h2222, "R7 original head");
    take(1'b0, 2'd2, 16'h2223, "R7 wb at tail");
    @(negedge clk);
    chk("R8 empty at end", {sw_valid, ed_valid}, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule